// File: doc/BRIEF.md
# Power-Good Output Sequencer

This block raises three active-high power-good outputs in a fixed order once the platform's rails report good. The outputs are a core-rail good for the processor, a hub power-ok and a system power-ok. They follow two inputs: a system-wide power-good input and a ready flag from the core voltage regulator. Each step waits a fixed number of milliseconds. The millisecond base comes from the system clock through a divider set by the parameter `CLK_KHZ`. The delay counter restarts from zero each time the sequencer changes state, so a wait of N ms lasts exactly N x `CLK_KHZ` clock cycles.

The sequence has four steps:
- Once the system input is high, the block waits `CORE_MS` and raises core-rail good.
- It then checks the regulator-ready flag once per millisecond, for at most `VR_TMO_MS` samples.
- After it sees the regulator ready, it waits `HUB_MS` and raises hub power-ok.
- After a further `SYS_MS` it raises system power-ok.

A loss of the system input at any point drops every output on the next clock. A regulator timeout also drops every output and sets a sticky fault flag. The flag is cleared only by the system input going low and then high again.

Top module: `pwrgood_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, all three outputs and `fault_o` are low.
- R2: In any state, if `sys_pg_i` is low at a clock edge, `core_good_o`, `hub_pok_o` and `sys_pok_o` are all low after that edge. No running timer delays this.
- R3: From the all-off state, the first edge that samples `sys_pg_i` high starts the sequence. `core_good_o` goes high exactly `CORE_MS`*`CLK_KHZ` edges later.
- R4: After `core_good_o` rises, `vr_rdy_i` is sampled only at every `CLK_KHZ`-th edge. At the first such edge that sees it high, a `HUB_MS` wait starts. `hub_pok_o` goes high `HUB_MS`*`CLK_KHZ` edges after that sampling edge.
- R5: `sys_pok_o` goes high `SYS_MS`*`CLK_KHZ` edges after `hub_pok_o` rises, provided `sys_pg_i` is still high at that edge.
- R6: If `vr_rdy_i` is low at all `VR_TMO_MS` sampling edges, all outputs drop and `fault_o` goes high at the last of them.
- R7: While `fault_o` is high, the outputs stay low whatever `vr_rdy_i` does. `fault_o` stays high through `sys_pg_i` going low. It clears only at the edge where a high `sys_pg_i` starts a new sequence from all-off.
- R8: Once `sys_pok_o` is high, changes on `vr_rdy_i` have no effect. All three outputs stay high for as long as `sys_pg_i` stays high.
- R9: `hub_pok_o` is never high without `core_good_o`, and `sys_pok_o` is never high without `hub_pok_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_pg_i | input | 1 | System-wide power-good |
| vr_rdy_i | input | 1 | Core regulator ready |
| core_good_o | output | 1 | Core-rail good to processor |
| hub_pok_o | output | 1 | Power-ok to platform hub |
| sys_pok_o | output | 1 | System power-ok to platform hub |
| fault_o | output | 1 | Sticky regulator-timeout flag |

## Verification
The hardest case to reach is the last-moment recheck: the system input is lost on the very edge that would raise system power-ok. The sticky fault is nearly as hard, because it must survive a full power-down before being cleared. The stimulus counts edges from the start of a sequence and drops `sys_pg_i` on exactly that final edge. Other runs drop it one edge earlier, or during the regulator wait. The regulator ready flag is also raised one cycle before and one cycle on a sampling boundary. This shows it is read only at millisecond boundaries. The timeout run keeps the regulator low for the full window, raises it afterwards, and then cycles the system input to show how the flag clears.

// File: rtl/pwrgood_seq_pkg.sv
package pwrgood_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_CORE  = 3'd1,
    ST_VRW   = 3'd2,
    ST_HUB   = 3'd3,
    ST_SYS   = 3'd4,
    ST_ON    = 3'd5,
    ST_FAULT = 3'd6
  } pgs_state_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/pgs_ms_timer.sv
module pgs_ms_timer #(
  parameter int CLK_KHZ = 1000,
  parameter int MS_W    = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  output logic            tick,
  output logic [MS_W-1:0] ms_cnt
);
  localparam int CYC_W = (CLK_KHZ > 1) ? $clog2(CLK_KHZ) : 1;
  localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CLK_KHZ - 1);

  logic [CYC_W-1:0] cyc_q;

  assign tick = (cyc_q == CYC_LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cyc_q <= '0;
    end else if (tick) begin
      cyc_q <= '0;
    end else begin
      cyc_q <= cyc_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ms_cnt <= '0;
    end else if (tick) begin
      ms_cnt <= ms_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pgs_fsm.sv
module pgs_fsm
  import pwrgood_seq_pkg::*;
#(
  parameter int MS_W      = 6,
  parameter int CORE_MS   = 2,
  parameter int VR_TMO_MS = 50,
  parameter int HUB_MS    = 2,
  parameter int SYS_MS    = 45
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sys_pg,
  input  logic            vr_rdy,
  input  logic            tick,
  input  logic [MS_W-1:0] ms_cnt,
  output logic            timer_clr,
  output logic            core_q,
  output logic            hub_q,
  output logic            sys_q,
  output logic            fault_q
);
  localparam logic [MS_W-1:0] CORE_LAST = MS_W'(CORE_MS - 1);
  localparam logic [MS_W-1:0] VR_LAST   = MS_W'(VR_TMO_MS - 1);
  localparam logic [MS_W-1:0] HUB_LAST  = MS_W'(HUB_MS - 1);
  localparam logic [MS_W-1:0] SYS_LAST  = MS_W'(SYS_MS - 1);

  pgs_state_t state_q, state_n;

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_OFF:   if (sys_pg) state_n = ST_CORE;
      ST_FAULT: if (!sys_pg) state_n = ST_OFF;
      ST_CORE: begin
        if (!sys_pg) state_n = ST_OFF;
        else if (tick && ms_cnt == CORE_LAST) state_n = ST_VRW;
      end
      ST_VRW: begin
        if (!sys_pg) state_n = ST_OFF;
        else if (tick && vr_rdy) state_n = ST_HUB;
        else if (tick && ms_cnt == VR_LAST) state_n = ST_FAULT;
      end
      ST_HUB: begin
        if (!sys_pg) state_n = ST_OFF;
        else if (tick && ms_cnt == HUB_LAST) state_n = ST_SYS;
      end
      ST_SYS: begin
        if (!sys_pg) state_n = ST_OFF;
        else if (tick && ms_cnt == SYS_LAST) state_n = ST_ON;
      end
      ST_ON:    if (!sys_pg) state_n = ST_OFF;
      default:  state_n = ST_OFF;
    endcase
  end

  assign timer_clr = (state_n != state_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_OFF;
      core_q  <= 1'b0;
      hub_q   <= 1'b0;
      sys_q   <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      state_q <= state_n;
      core_q  <= (state_n == ST_VRW) || (state_n == ST_HUB) ||
                 (state_n == ST_SYS) || (state_n == ST_ON);
      hub_q   <= (state_n == ST_SYS) || (state_n == ST_ON);
      sys_q   <= (state_n == ST_ON);
      if (state_q == ST_OFF && state_n == ST_CORE) begin
        fault_q <= 1'b0;
      end else if (state_n == ST_FAULT) begin
        fault_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwrgood_seq.sv
module pwrgood_seq #(
  parameter int CLK_KHZ   = 100000,
  parameter int CORE_MS   = 2,
  parameter int VR_TMO_MS = 50,
  parameter int HUB_MS    = 2,
  parameter int SYS_MS    = 45
) (
  input  logic clk,
  input  logic rst,
  input  logic sys_pg_i,
  input  logic vr_rdy_i,
  output logic core_good_o,
  output logic hub_pok_o,
  output logic sys_pok_o,
  output logic fault_o
);
  localparam int MAX_MS = pwrgood_seq_pkg::max2(pwrgood_seq_pkg::max2(CORE_MS, VR_TMO_MS),
                                                pwrgood_seq_pkg::max2(HUB_MS, SYS_MS));
  localparam int MS_W   = $clog2(MAX_MS + 1);

  logic            tick;
  logic            timer_clr;
  logic [MS_W-1:0] ms_cnt;

  pgs_ms_timer #(.CLK_KHZ(CLK_KHZ), .MS_W(MS_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .clr    (timer_clr),
    .tick   (tick),
    .ms_cnt (ms_cnt)
  );

  pgs_fsm #(
    .MS_W(MS_W), .CORE_MS(CORE_MS), .VR_TMO_MS(VR_TMO_MS),
    .HUB_MS(HUB_MS), .SYS_MS(SYS_MS)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .sys_pg    (sys_pg_i),
    .vr_rdy    (vr_rdy_i),
    .tick      (tick),
    .ms_cnt    (ms_cnt),
    .timer_clr (timer_clr),
    .core_q    (core_good_o),
    .hub_q     (hub_pok_o),
    .sys_q     (sys_pok_o),
    .fault_q   (fault_o)
  );
endmodule

// File: rtl/pwrgood_seq_chk.sv
module pwrgood_seq_chk (
  input logic clk,
  input logic rst,
  input logic sys_pg_i,
  input logic vr_rdy_i,
  input logic core_good_o,
  input logic hub_pok_o,
  input logic sys_pok_o,
  input logic fault_o
);
  // R2
  sys_loss_off_chk: assert property (@(posedge clk) disable iff (rst)
    !sys_pg_i |=> (!core_good_o && !hub_pok_o && !sys_pok_o));

  // R9
  hub_needs_core_chk: assert property (@(posedge clk) disable iff (rst)
    hub_pok_o |-> core_good_o);

  // R9
  sys_needs_hub_chk: assert property (@(posedge clk) disable iff (rst)
    sys_pok_o |-> hub_pok_o);

  // R7
  fault_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> (!core_good_o && !hub_pok_o && !sys_pok_o));

  // R5
  sys_rise_pg_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_pok_o) |-> $past(sys_pg_i));

  // R8
  on_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (sys_pok_o && sys_pg_i) |=> (sys_pok_o && hub_pok_o && core_good_o));

  // R7
  fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (fault_o && !sys_pg_i) |=> fault_o);
endmodule

bind pwrgood_seq pwrgood_seq_chk u_chk (
  .clk(clk), .rst(rst), .sys_pg_i(sys_pg_i), .vr_rdy_i(vr_rdy_i),
  .core_good_o(core_good_o), .hub_pok_o(hub_pok_o),
  .sys_pok_o(sys_pok_o), .fault_o(fault_o)
);

// File: tb/pwrgood_seq_test.sv
`timescale 1ns/1ps
module pwrgood_seq_test;
  localparam int K = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sys_pg = 1'b0;
  logic vr_rdy = 1'b0;
  logic core_good, hub_pok, sys_pok, fault;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  pwrgood_seq #(.CLK_KHZ(K)) uut (
    .clk(clk), .rst(rst), .sys_pg_i(sys_pg), .vr_rdy_i(vr_rdy),
    .core_good_o(core_good), .hub_pok_o(hub_pok),
    .sys_pok_o(sys_pok), .fault_o(fault)
  );

  // Behavioural reference: phase and cycles spent in the phase.
  int m_ph = 0;
  int m_cyc = 0;
  bit m_fault = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_cyc = 0; m_fault = 1'b0;
    end else if (m_ph == 0) begin
      if (sys_pg) begin m_ph = 1; m_cyc = 0; m_fault = 1'b0; end
    end else if (m_ph == 6) begin
      if (!sys_pg) begin m_ph = 0; m_cyc = 0; end
    end else if (!sys_pg) begin
      m_ph = 0; m_cyc = 0;
    end else if (m_ph != 5) begin
      m_cyc = m_cyc + 1;
      case (m_ph)
        1: if (m_cyc == 2*K) begin m_ph = 2; m_cyc = 0; end
        2: if (m_cyc % K == 0) begin
             if (vr_rdy) begin m_ph = 3; m_cyc = 0; end
             else if (m_cyc == 50*K) begin m_ph = 6; m_cyc = 0; m_fault = 1'b1; end
           end
        3: if (m_cyc == 2*K) begin m_ph = 4; m_cyc = 0; end
        4: if (m_cyc == 45*K) begin m_ph = 5; m_cyc = 0; end
        default: ;
      endcase
    end
  end

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the reference model.
  always @(negedge clk) begin
    if (!rst) begin
      chk("R3", core_good, (m_ph >= 2 && m_ph <= 5), "core_good");
      chk("R4", hub_pok, (m_ph == 4 || m_ph == 5), "hub_pok");
      chk("R5", sys_pok, (m_ph == 5), "sys_pok");
      chk("R6", fault, m_fault, "fault");
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    #1500000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    cyc(3);
    // R1: reset state
    chk("R1", core_good | hub_pok | sys_pok | fault, 1'b0, "outputs in reset");
    rst = 1'b0;
    cyc(1);
    chk("R1", core_good | hub_pok | sys_pok | fault, 1'b0, "outputs after reset");

    // Full power-up; regulator ready between boundaries.
    sys_pg = 1'b1;
    cyc(2*K);
    chk("R3", core_good, 1'b0, "core one edge early");
    cyc(1);
    chk("R3", core_good, 1'b1, "core on time");
    cyc(3*K + 3);
    vr_rdy = 1'b1;
    cyc(2*K + K);
    chk("R4", hub_pok, 1'b1, "hub after ready");
    cyc(45*K + 5);
    chk("R5", sys_pok, 1'b1, "sys_pok after delay");
    // R8: regulator drops while on
    vr_rdy = 1'b0;
    cyc(3*K);
    chk("R8", sys_pok & hub_pok & core_good, 1'b1, "steady while on");
    vr_rdy = 1'b1;
    cyc(K);
    // R2: loss while on
    sys_pg = 1'b0;
    cyc(1);
    chk("R2", core_good | hub_pok | sys_pok, 1'b0, "all off after loss");
    cyc(5);

    // Loss exactly on the final recheck edge (R5/R2).
    sys_pg = 1'b1;
    cyc(2*K + 1 + K + 2*K + 45*K - 1);
    chk("R5", sys_pok, 1'b0, "still waiting before recheck");
    sys_pg = 1'b0;
    cyc(1);
    chk("R2", sys_pok | hub_pok | core_good, 1'b0, "recheck saw loss");
    cyc(4);

    // Loss during regulator wait (R2).
    vr_rdy = 1'b0;
    sys_pg = 1'b1;
    cyc(2*K + 1 + 7);
    sys_pg = 1'b0;
    cyc(1);
    chk("R2", core_good, 1'b0, "loss in regulator wait");
    cyc(3);

    // R4: ready one cycle before a boundary is not seen until the boundary.
    sys_pg = 1'b1;
    cyc(2*K + 1 + K - 2);
    vr_rdy = 1'b1;
    cyc(1);
    vr_rdy = 1'b0;
    cyc(K);
    chk("R4", hub_pok, 1'b0, "ready off-boundary ignored");
    vr_rdy = 1'b1;
    cyc(K + 2*K + 1);
    chk("R4", hub_pok, 1'b1, "ready on boundary seen");
    sys_pg = 1'b0;
    cyc(4);

    // R6: timeout.
    vr_rdy = 1'b0;
    sys_pg = 1'b1;
    cyc(2*K + 50*K);
    chk("R6", fault, 1'b0, "no fault before last sample");
    cyc(1);
    chk("R6", fault, 1'b1, "fault at timeout");
    chk("R6", core_good, 1'b0, "core dropped at timeout");
    // R7: regulator ready afterwards has no effect.
    vr_rdy = 1'b1;
    cyc(5*K);
    chk("R7", core_good | hub_pok | sys_pok, 1'b0, "quiet in fault");
    chk("R7", fault, 1'b1, "fault held");
    sys_pg = 1'b0;
    cyc(3);
    chk("R7", fault, 1'b1, "fault through power loss");
    sys_pg = 1'b1;
    cyc(1);
    chk("R7", fault, 1'b0, "fault cleared on restart");
    // R9: restart completes normally
    cyc(2*K + K + 2*K + 45*K + 2);
    chk("R9", sys_pok & hub_pok & core_good, 1'b1, "ordered power-up");
    sys_pg = 1'b0;
    cyc(3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule